// File: doc/BRIEF.md
# ALU Operand and Program Counter Select Unit

This block sits between the datapath registers of a multicycle 32-bit processor and its single shared ALU. Each cycle the control sequencer picks the ALU's two operands: the first is either the program counter or the register-A latch. The second is one of four values: the register-B latch, the constant 4, the sign-extended 16-bit immediate, or that immediate multiplied by four. The fourth choice lets the sequencer compute a branch target early, during decode, before it knows whether the instruction is a branch.

The block also owns the program counter register. It builds a jump target by keeping the top bits of the current counter and filling the rest with the 26-bit instruction index shifted left by two. It then loads the counter from one of three sources: the live ALU result, the registered ALU output, or the jump target. The load enable is formed from an unconditional write request and a conditional write request. The conditional request takes effect only when the ALU reports a zero result. The ALU, the register file and the sequencer are outside this block.

Top module: `alu_pc_sel_unit`

## Requirements
- R1: `op_a` equals `pc_q` when `sel_a` is 0 and `reg_a` when `sel_a` is 1, in the same cycle.
- R2: `op_b` equals `reg_b` when `sel_b` is 2'b00 and the value 4 when `sel_b` is 2'b01.
- R3: When `sel_b` is 2'b10, `op_b` is `ir_field[15:0]` sign-extended to 32 bits, with bit 15 copied into bits 31..16.
- R4: When `sel_b` is 2'b11, `op_b` is the R3 value shifted left by two, so its bits 1..0 are zero.
- R5: `jump_tgt` equals `{pc_q[31:28], ir_field[25:0], 2'b00}` and is formed from the value the counter register holds now.
- R6: `pc_load` is 1 exactly when `pc_wr` is 1, or when both `pc_wr_cond` and `alu_zero` are 1.
- R7: When `pc_load` is 1 at a rising edge, `pc_q` takes a new value after that edge. With `pc_src` 2'b00 it takes `alu_result`. With 2'b01 it takes `alu_out_q`. With 2'b10 it takes `jump_tgt`.
- R8: `pc_src` 2'b11 is reserved: `pc_q` keeps its value across the edge even when `pc_load` is 1.
- R9: When `pc_load` is 0, `pc_q` keeps its value. This includes a conditional write with `alu_zero` at 0.
- R10: `rst` is synchronous and active high. At an edge where `rst` is 1, `pc_q` becomes 32'h0000_0000, and this takes priority over any write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sel_a | input | 1 | First-operand select |
| sel_b | input | 2 | Second-operand select |
| pc_src | input | 2 | Next counter source select |
| pc_wr | input | 1 | Unconditional counter write |
| pc_wr_cond | input | 1 | Conditional counter write, gated by zero |
| alu_zero | input | 1 | ALU zero flag |
| reg_a | input | 32 | Register-A latch value |
| reg_b | input | 32 | Register-B latch value |
| ir_field | input | 26 | Instruction bits 25..0 (the immediate is bits 15..0) |
| alu_result | input | 32 | Live ALU result |
| alu_out_q | input | 32 | Registered ALU result |
| op_a | output | 32 | ALU first operand |
| op_b | output | 32 | ALU second operand |
| jump_tgt | output | 32 | Formed jump target |
| pc_load | output | 1 | Counter load enable |
| pc_q | output | 32 | Program counter |

## Verification
The operand outputs, the jump target and the load enable are combinational. The bench therefore checks them one time unit after it drives new inputs at a falling edge, well before the next rising edge. The counter is the only register, so its effect shows one rising edge later. The bench compares `pc_q` at the following falling edge against a model value that it updated for that single edge. Each counter check is tagged with the rule that applied at that edge: reset, a source load, the reserved source, or a hold.

// File: rtl/opsel_pkg.sv
package opsel_pkg;
   typedef enum logic {
      A_PC  = 1'b0,
      A_REG = 1'b1
   } src_a_e;

   typedef enum logic [1:0] {
      B_REG    = 2'b00,
      B_FOUR   = 2'b01,
      B_IMM    = 2'b10,
      B_IMM_SH = 2'b11
   } src_b_e;

   typedef enum logic [1:0] {
      PC_ALU    = 2'b00,
      PC_ALUOUT = 2'b01,
      PC_JUMP   = 2'b10,
      PC_RSVD   = 2'b11
   } pc_src_e;
endpackage

// File: rtl/opsel_a_mux.sv
module opsel_a_mux #(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            sel_a,
   input  logic [XLEN-1:0] pc_q,
   input  logic [XLEN-1:0] reg_a,
   output logic [XLEN-1:0] op_a
);
   import opsel_pkg::*;

   if (XLEN < 2) begin : g_bad_xlen
      $error("opsel_a_mux: XLEN too small");
   end

   always_comb begin
      unique case (src_a_e'(sel_a))
         A_PC:    op_a = pc_q;
         default: op_a = reg_a;
      endcase
   end

   // R1: a register-sourced operand never changes while its source is held
   p_a_follow_r1: assert property (@(posedge clk) disable iff (rst)
      (sel_a && $past(sel_a) && $stable(reg_a)) |-> $stable(op_a));
endmodule

// File: rtl/opsel_b_mux.sv
module opsel_b_mux #(
   parameter int XLEN   = 32,
   parameter int IMM_W  = 16,
   parameter int SHIFT  = 2,
   parameter int STRIDE = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       sel_b,
   input  logic [XLEN-1:0]  reg_b,
   input  logic [IMM_W-1:0] imm,
   output logic [XLEN-1:0]  op_b
);
   import opsel_pkg::*;

   localparam int EXT_W = XLEN - IMM_W;

   if (XLEN <= IMM_W + SHIFT) begin : g_bad_width
      $error("opsel_b_mux: XLEN must exceed IMM_W + SHIFT");
   end
   if (STRIDE != (1 << SHIFT)) begin : g_bad_stride
      $error("opsel_b_mux: STRIDE must equal 2**SHIFT");
   end

   logic [XLEN-1:0] imm_ext;
   logic [XLEN-1:0] imm_scaled;

   assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};

   if (SHIFT == 0) begin : g_noshift
      assign imm_scaled = imm_ext;
   end else begin : g_shift
      assign imm_scaled = {imm_ext[XLEN-1-SHIFT:0], {SHIFT{1'b0}}};
   end

   always_comb begin
      unique case (src_b_e'(sel_b))
         B_REG:    op_b = reg_b;
         B_FOUR:   op_b = XLEN'(STRIDE);
         B_IMM:    op_b = imm_ext;
         default:  op_b = imm_scaled;
      endcase
   end

   // R3: every upper bit carries the immediate's sign
   p_sign_fill_r3: assert property (@(posedge clk) disable iff (rst)
      (sel_b == B_IMM) |->
         (op_b[XLEN-1:IMM_W] == {EXT_W{imm[IMM_W-1]}}) && (op_b[IMM_W-1:0] == imm));
   // R4: the scaled immediate is a multiple of the stride and keeps the sign
   p_scaled_r4: assert property (@(posedge clk) disable iff (rst)
      (sel_b == B_IMM_SH) |->
         (op_b[SHIFT-1:0] == '0) && (op_b[XLEN-1] == imm[IMM_W-1]));
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit #(
   parameter int              XLEN     = 32,
   parameter int              JIDX_W   = 26,
   parameter int              SHIFT    = 2,
   parameter logic [XLEN-1:0] RESET_PC = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        pc_src,
   input  logic              pc_wr,
   input  logic              pc_wr_cond,
   input  logic              alu_zero,
   input  logic [JIDX_W-1:0] jidx,
   input  logic [XLEN-1:0]   alu_result,
   input  logic [XLEN-1:0]   alu_out_q,
   output logic [XLEN-1:0]   jump_tgt,
   output logic              pc_load,
   output logic [XLEN-1:0]   pc_q
);
   import opsel_pkg::*;

   localparam int HI_W = XLEN - JIDX_W - SHIFT;

   if (HI_W < 1) begin : g_bad_jidx
      $error("pc_next_unit: jump index leaves no upper counter bits");
   end

   logic [XLEN-1:0] pc_d;
   logic            take;

   assign jump_tgt = {pc_q[XLEN-1 -: HI_W], jidx, {SHIFT{1'b0}}};
   assign pc_load  = pc_wr | (pc_wr_cond & alu_zero);

   always_comb begin
      take = pc_load;
      pc_d = pc_q;
      unique case (pc_src_e'(pc_src))
         PC_ALU:    pc_d = alu_result;
         PC_ALUOUT: pc_d = alu_out_q;
         PC_JUMP:   pc_d = jump_tgt;
         default:   take = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)       pc_q <= RESET_PC;
      else if (take) pc_q <= pc_d;
   end

   // R10: reset sets the counter regardless of any write request
   p_reset_r10: assert property (@(posedge clk) rst |=> (pc_q == RESET_PC));
   // R9: no load means no change
   p_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !pc_load |=> $stable(pc_q));
   // R8: reserved source never moves the counter
   p_rsvd_r8: assert property (@(posedge clk) disable iff (rst)
      (pc_load && pc_src == PC_RSVD) |=> $stable(pc_q));
   // R7: each source lands in the counter one edge later
   p_from_alu_r7: assert property (@(posedge clk) disable iff (rst)
      (pc_load && pc_src == PC_ALU) |=> (pc_q == $past(alu_result)));
   p_from_out_r7: assert property (@(posedge clk) disable iff (rst)
      (pc_load && pc_src == PC_ALUOUT) |=> (pc_q == $past(alu_out_q)));
   // R6: a failed condition with no unconditional request gives no load
   p_cond_gate_r6: assert property (@(posedge clk) disable iff (rst)
      (!pc_wr && !(pc_wr_cond && alu_zero)) |-> !pc_load);
   // R5: the target's upper bits track the counter register
   p_jump_hi_r5: assert property (@(posedge clk) disable iff (rst)
      (jump_tgt[XLEN-1 -: HI_W] == pc_q[XLEN-1 -: HI_W]) && (jump_tgt[SHIFT-1:0] == '0));
endmodule

// File: rtl/alu_pc_sel_unit.sv
module alu_pc_sel_unit #(
   parameter int              XLEN     = 32,
   parameter int              IMM_W    = 16,
   parameter int              JIDX_W   = 26,
   parameter int              SHIFT    = 2,
   parameter logic [XLEN-1:0] RESET_PC = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sel_a,
   input  logic [1:0]        sel_b,
   input  logic [1:0]        pc_src,
   input  logic              pc_wr,
   input  logic              pc_wr_cond,
   input  logic              alu_zero,
   input  logic [XLEN-1:0]   reg_a,
   input  logic [XLEN-1:0]   reg_b,
   input  logic [JIDX_W-1:0] ir_field,
   input  logic [XLEN-1:0]   alu_result,
   input  logic [XLEN-1:0]   alu_out_q,
   output logic [XLEN-1:0]   op_a,
   output logic [XLEN-1:0]   op_b,
   output logic [XLEN-1:0]   jump_tgt,
   output logic              pc_load,
   output logic [XLEN-1:0]   pc_q
);
   localparam int STRIDE = 1 << SHIFT;

   if (JIDX_W < IMM_W) begin : g_bad_field
      $error("alu_pc_sel_unit: immediate must fit inside the jump index");
   end

   opsel_a_mux #(.XLEN(XLEN)) u_amux (
      .clk(clk), .rst(rst), .sel_a(sel_a), .pc_q(pc_q), .reg_a(reg_a), .op_a(op_a)
   );

   opsel_b_mux #(.XLEN(XLEN), .IMM_W(IMM_W), .SHIFT(SHIFT), .STRIDE(STRIDE)) u_bmux (
      .clk(clk), .rst(rst), .sel_b(sel_b), .reg_b(reg_b),
      .imm(ir_field[IMM_W-1:0]), .op_b(op_b)
   );

   pc_next_unit #(.XLEN(XLEN), .JIDX_W(JIDX_W), .SHIFT(SHIFT), .RESET_PC(RESET_PC)) u_pc (
      .clk(clk), .rst(rst), .pc_src(pc_src), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
      .alu_zero(alu_zero), .jidx(ir_field), .alu_result(alu_result),
      .alu_out_q(alu_out_q), .jump_tgt(jump_tgt), .pc_load(pc_load), .pc_q(pc_q)
   );
endmodule

// File: tb/sim_alu_pc_sel_unit.sv
module sim_alu_pc_sel_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst, sel_a, pc_wr, pc_wr_cond, alu_zero;
   logic [1:0]  sel_b, pc_src;
   logic [31:0] reg_a, reg_b, alu_result, alu_out_q;
   logic [25:0] ir_field;
   logic [31:0] op_a, op_b, jump_tgt, pc_q;
   logic        pc_load;

   int          n_vec = 0;
   int          n_bad = 0;
   logic [31:0] exp_pc = '0;
   bit          pc_known = 1'b0;
   string       pc_tag = "R10";

   always #(CLK_PERIOD/2) clk = ~clk;

   alu_pc_sel_unit u0 (
      .clk(clk), .rst(rst), .sel_a(sel_a), .sel_b(sel_b), .pc_src(pc_src),
      .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .alu_zero(alu_zero),
      .reg_a(reg_a), .reg_b(reg_b), .ir_field(ir_field), .alu_result(alu_result),
      .alu_out_q(alu_out_q), .op_a(op_a), .op_b(op_b), .jump_tgt(jump_tgt),
      .pc_load(pc_load), .pc_q(pc_q)
   );

   function automatic logic [31:0] f_sext(input logic [15:0] v);
      return {{16{v[15]}}, v};
   endfunction

   function automatic logic [31:0] f_op_b(input logic [1:0] s, input logic [31:0] b,
                                          input logic [25:0] f);
      case (s)
         2'b00:   return b;
         2'b01:   return 32'd4;
         2'b10:   return f_sext(f[15:0]);
         default: return f_sext(f[15:0]) << 2;
      endcase
   endfunction

   function automatic logic [31:0] f_jump(input logic [31:0] pc, input logic [25:0] f);
      return {pc[31:28], f, 2'b00};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input logic r, input logic sa, input logic [1:0] sb,
                       input logic [1:0] ps, input logic w, input logic wc,
                       input logic z, input logic [31:0] a, input logic [31:0] b,
                       input logic [25:0] f, input logic [31:0] ar, input logic [31:0] ao);
      logic        ld;
      logic [31:0] src;
      @(negedge clk);
      if (pc_known) chk({pc_tag, " pc_q"}, pc_q, exp_pc);
      rst = r; sel_a = sa; sel_b = sb; pc_src = ps; pc_wr = w; pc_wr_cond = wc;
      alu_zero = z; reg_a = a; reg_b = b; ir_field = f; alu_result = ar; alu_out_q = ao;
      #1;
      if (pc_known) begin
         chk("R1 op_a", op_a, sa ? a : exp_pc);
         chk(sb == 2'b10 ? "R3 op_b" : (sb == 2'b11 ? "R4 op_b" : "R2 op_b"),
             op_b, f_op_b(sb, b, f));
         chk("R5 jump_tgt", jump_tgt, f_jump(exp_pc, f));
      end
      ld = w | (wc & z);
      chk("R6 pc_load", {31'd0, pc_load}, {31'd0, ld});
      case (ps)
         2'b00:   src = ar;
         2'b01:   src = ao;
         default: src = f_jump(exp_pc, f);
      endcase
      if (r) begin
         exp_pc = '0; pc_tag = "R10"; pc_known = 1'b1;
      end else if (ld && ps != 2'b11) begin
         exp_pc = src; pc_tag = "R7";
      end else if (ld) begin
         pc_tag = "R8";
      end else begin
         pc_tag = "R9";
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      rst = 1'b1; sel_a = 0; sel_b = 0; pc_src = 0; pc_wr = 0; pc_wr_cond = 0;
      alu_zero = 0; reg_a = 0; reg_b = 0; ir_field = 0; alu_result = 0; alu_out_q = 0;
      // R10: reset beats an unconditional write
      step(1, 0, 2'b00, 2'b00, 1, 0, 0, 32'h1, 32'h2, 26'h0, 32'hDEAD_BEEF, 32'h0);
      // R7: load from the live ALU result
      step(0, 0, 2'b01, 2'b00, 1, 0, 0, 32'h11, 32'h22, 26'h0, 32'hF000_0004, 32'h5);
      // R3 and R4: negative and positive immediates
      step(0, 1, 2'b10, 2'b00, 0, 0, 0, 32'hA, 32'hB, 26'h000_8000, 32'h0, 32'h0);
      step(0, 1, 2'b11, 2'b00, 0, 0, 0, 32'hA, 32'hB, 26'h000_8000, 32'h0, 32'h0);
      step(0, 0, 2'b10, 2'b00, 0, 0, 0, 32'hA, 32'hB, 26'h000_7FFF, 32'h0, 32'h0);
      step(0, 0, 2'b11, 2'b00, 0, 0, 0, 32'hA, 32'hB, 26'h000_7FFF, 32'h0, 32'h0);
      // R9: conditional write with zero clear leaves the counter alone
      step(0, 0, 2'b00, 2'b01, 0, 1, 0, 32'h0, 32'h0, 26'h0, 32'h0, 32'h1234_5678);
      // R6 and R7: conditional write with zero set takes the registered result
      step(0, 0, 2'b00, 2'b01, 0, 1, 1, 32'h0, 32'h0, 26'h0, 32'h0, 32'hA000_0010);
      // R5 and R7: jump keeps upper counter bits
      step(0, 0, 2'b00, 2'b10, 1, 0, 0, 32'h0, 32'h0, 26'h3FF_FFFF, 32'h0, 32'h0);
      // R8: reserved source with both write requests
      step(0, 0, 2'b00, 2'b11, 1, 1, 1, 32'h0, 32'h0, 26'h0, 32'h5555_5555, 32'h6666_6666);
      for (int i = 0; i < 400; i++) begin
         step(($urandom % 32) == 0, 1'($urandom), 2'($urandom), 2'($urandom),
              ($urandom % 3) == 0, 1'($urandom), 1'($urandom), $urandom, $urandom,
              26'($urandom), $urandom, $urandom);
      end
      step(0, 0, 2'b00, 2'b00, 0, 0, 0, 32'h0, 32'h0, 26'h0, 32'h0, 32'h0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule